// File: doc/BRIEF.md
# Differential Crossbar Read-Out Sequencer

This block sequences one analog vector-matrix multiply on a pair of resistive crossbars that together hold signed weights. One crossbar carries the positive weights and the other the negative weights. A binary input vector selects which rows take part. On each selected row, the positive crossbar is driven to the positive read reference and the negative crossbar to the negative read reference. Every unselected row stays at common mode. Each column therefore carries the summed current of every driven cell.

Once the row drives are applied, the sequencer waits a settling time given as a count of clock cycles. It then requests a conversion from a multi-channel ADC. The ADC has fewer channels than the crossbar has columns, so the columns are read in groups. The sequencer selects one group, lets the lines settle, converts, and stores the channel words in a per-column result buffer. It repeats this for the next group. After the last group it returns every row to common mode and raises a done flag.

Top module: `xbar_readout_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0, adc_start_o is 0, col_grp_o is 0, every row code is 2'b00 and every result word is 0.
- R2: Row r owns bits [2r+1:2r] of each row-code bus. The code values are 2'b00 for common mode, 2'b01 for the positive reference and 2'b10 for the negative reference. While a multiply is busy, a row whose bit is 1 reads 2'b01 on pos_row_code_o and 2'b10 on neg_row_code_o, and a row whose bit is 0 reads 2'b00 on both.
- R3: A start is accepted when start_i is high while the block is idle. Let N be the value of settle_cycles_i in that cycle. Exactly N+1 clock cycles lie between the accepted start cycle and the first cycle with adc_start_o high. A later change to settle_cycles_i has no effect on the multiply that is running.
- R4: adc_start_o is high for exactly one cycle per column group. col_grp_o does not change between that pulse and the cycle in which adc_done_i is high.
- R5: The groups are visited in the order 0, 1, 2. In group g, ADC channel k (bits [12k+11:12k] of adc_data_i) belongs to column 10g+k. Channels that map to columns above 24 are discarded.
- R6: After a non-final group, exactly N+1 clock cycles lie between the cycle in which adc_done_i is high and the next adc_start_o pulse.
- R7: Column c's word appears at bits [12c+11:12c] of result_o and equals the ADC word captured for that column. It holds until a later multiply overwrites it.
- R8: After the final conversion, all row codes are 2'b00 for one cycle while busy_o is still 1. done_o rises at the end of that cycle.
- R9: busy_o is high from the cycle after an accepted start until done_o rises. done_o then stays high until the next accepted start. A start_i pulse while busy, including one in the cycle of the final conversion, is ignored.
- R10: adc_done_i raised while no conversion is outstanding changes no result word and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one multiply |
| vec_i | input | 25 | Binary input vector, bit r selects row r |
| settle_cycles_i | input | 16 | Settling count N, sampled at start |
| pos_row_code_o | output | 50 | Two-bit drive code per row, positive crossbar |
| neg_row_code_o | output | 50 | Two-bit drive code per row, negative crossbar |
| col_grp_o | output | 2 | Column group routed to the ADC channels |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_done_i | input | 1 | Conversion complete, adc_data_i valid |
| adc_data_i | input | 120 | Ten 12-bit channel words |
| result_o | output | 300 | Twenty-five 12-bit column words |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | Last multiply complete, results valid |

## Verification
Two events can fall in the same cycle. The first pair is the final group's conversion completing and a new start strobe arriving. In that cycle the block must capture the last words and begin releasing the rows, while the start must have no effect. The bench provokes this by raising start_i with an inverted vector on the same falling edge at which it raises adc_done_i for group 2. It holds the strobe through the release cycle, then checks three things: the results still match the original vector, done_o stays high, and busy_o stays low. The second pair is a conversion request and a conversion result in the same cycle. With an ADC latency of zero, adc_done_i is high during the cycle that carries the adc_start_o pulse, and the bench checks that the capture and the following group timing stay correct.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CONV,
    ST_RELEASE
  } seq_state_e;

  localparam logic [1:0] DRV_CM   = 2'b00;
  localparam logic [1:0] DRV_REFP = 2'b01;
  localparam logic [1:0] DRV_REFN = 2'b10;

  function automatic int unsigned group_count(int unsigned cols, int unsigned chans);
    return (cols + chans - 1) / chans;
  endfunction

  function automatic int unsigned col_group(int unsigned col, int unsigned chans);
    return col / chans;
  endfunction

  function automatic int unsigned col_chan(int unsigned col, int unsigned chans);
    return col % chans;
  endfunction

endpackage

// File: rtl/xbar_row_drive.sv
module xbar_row_drive
  import xbar_pkg::*;
#(
  parameter int ROWS = 25
) (
  input  logic              en,
  input  logic [ROWS-1:0]   vec,
  output logic [2*ROWS-1:0] pos_code,
  output logic [2*ROWS-1:0] neg_code
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign pos_code[2*r +: 2] = (en && vec[r]) ? DRV_REFP : DRV_CM;
    assign neg_code[2*r +: 2] = (en && vec[r]) ? DRV_REFN : DRV_CM;
  end

endmodule

// File: rtl/xbar_settle_timer.sv
module xbar_settle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

  // R3 / R6: the settle window shrinks by one per running cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R6: an idle timer keeps its value
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/xbar_result_buf.sv
module xbar_result_buf
  import xbar_pkg::*;
#(
  parameter int COLS  = 25,
  parameter int CHANS = 10,
  parameter int ADC_W = 12,
  parameter int GRP_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap,
  input  logic [GRP_W-1:0]       grp,
  input  logic [CHANS*ADC_W-1:0] adc_data,
  output logic [COLS*ADC_W-1:0]  result
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int unsigned GRP = col_group(c, CHANS);
    localparam int unsigned CH  = col_chan(c, CHANS);
    logic [ADC_W-1:0] word_q;
    logic             hit;

    assign hit = cap && (grp == GRP_W'(GRP));

    always_ff @(posedge clk) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= adc_data[CH*ADC_W +: ADC_W];
    end

    assign result[c*ADC_W +: ADC_W] = word_q;
  end

  // R7 / R10: without a capture strobe the buffer holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(result));

endmodule

// File: rtl/xbar_readout_seq.sv
module xbar_readout_seq
  import xbar_pkg::*;
#(
  parameter int ROWS     = 25,
  parameter int COLS     = 25,
  parameter int CHANNELS = 10,
  parameter int ADC_W    = 12,
  parameter int SETTLE_W = 16,
  localparam int NGRP    = group_count(COLS, CHANNELS),
  localparam int GRP_W   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [ROWS-1:0]           vec_i,
  input  logic [SETTLE_W-1:0]       settle_cycles_i,
  output logic [2*ROWS-1:0]         pos_row_code_o,
  output logic [2*ROWS-1:0]         neg_row_code_o,
  output logic [GRP_W-1:0]          col_grp_o,
  output logic                      adc_start_o,
  input  logic                      adc_done_i,
  input  logic [CHANNELS*ADC_W-1:0] adc_data_i,
  output logic [COLS*ADC_W-1:0]     result_o,
  output logic                      busy_o,
  output logic                      done_o
);

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NGRP - 1);

  seq_state_e          state_q;
  logic [ROWS-1:0]     vec_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [GRP_W-1:0]    grp_q;
  logic                drive_en_q;
  logic                adc_go_q;
  logic                done_q;

  // named internal events
  logic accept_start;
  logic settle_done;
  logic conv_done;
  logic last_group;
  logic next_group;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign conv_done    = (state_q == ST_CONV) && adc_done_i;
  assign last_group   = (grp_q == LAST_GRP);
  assign next_group   = conv_done && !last_group;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vec_q      <= '0;
      settle_q   <= '0;
      grp_q      <= '0;
      drive_en_q <= 1'b0;
      adc_go_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      adc_go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vec_q      <= vec_i;
          settle_q   <= settle_cycles_i;
          grp_q      <= '0;
          drive_en_q <= 1'b1;
          done_q     <= 1'b0;
          state_q    <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done) begin
          adc_go_q <= 1'b1;
          state_q  <= ST_CONV;
        end
        ST_CONV: if (adc_done_i) begin
          if (last_group) begin
            drive_en_q <= 1'b0;
            state_q    <= ST_RELEASE;
          end else begin
            grp_q   <= grp_q + GRP_W'(1);
            state_q <= ST_SETTLE;
          end
        end
        ST_RELEASE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  xbar_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_start || next_group),
    .load_val (accept_start ? settle_cycles_i : settle_q),
    .run      (state_q == ST_SETTLE),
    .expired  (settle_done)
  );

  xbar_row_drive #(.ROWS(ROWS)) u_drive (
    .en       (drive_en_q),
    .vec      (vec_q),
    .pos_code (pos_row_code_o),
    .neg_code (neg_row_code_o)
  );

  xbar_result_buf #(
    .COLS(COLS), .CHANS(CHANNELS), .ADC_W(ADC_W), .GRP_W(GRP_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (conv_done),
    .grp      (grp_q),
    .adc_data (adc_data_i),
    .result   (result_o)
  );

  assign col_grp_o   = grp_q;
  assign adc_start_o = adc_go_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  // R4: conversion request is a single-cycle pulse
  p_adc_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);

  // R4: group select steady while a conversion is outstanding
  p_grp_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && !adc_done_i) |=> $stable(col_grp_o));

  // R5: group index never passes the last group
  p_grp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_grp_o <= LAST_GRP);

  // R8: release cycle drives common mode while still busy
  p_release_cm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE) |-> (pos_row_code_o == '0 && neg_row_code_o == '0 && busy_o));

  // R8: done only rises out of the release cycle
  p_done_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state_q) == ST_RELEASE));

  // R9: busy and done never overlap
  p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R9: a start while busy leaves the captured vector alone
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(vec_q));

  // R10: a stray completion outside conversion captures nothing
  p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done_i && state_q != ST_CONV) |=> $stable(result_o));

endmodule

// File: tb/sim_xbar_readout_seq.sv
module sim_xbar_readout_seq;

  localparam int ROWS = 25, COLS = 25, CH = 10, AW = 12, NGRP = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start_i = 1'b0;
  logic [ROWS-1:0]     vec_i = '0;
  logic [15:0]         settle_cycles_i = '0;
  logic [2*ROWS-1:0]   pos_row_code_o, neg_row_code_o;
  logic [1:0]          col_grp_o;
  logic                adc_start_o;
  logic                adc_done_i = 1'b0;
  logic [CH*AW-1:0]    adc_data_i = '0;
  logic [COLS*AW-1:0]  result_o;
  logic                busy_o, done_o;

  always #5 clk = ~clk;

  xbar_readout_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_i),
    .settle_cycles_i(settle_cycles_i), .pos_row_code_o(pos_row_code_o),
    .neg_row_code_o(neg_row_code_o), .col_grp_o(col_grp_o),
    .adc_start_o(adc_start_o), .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
    .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [ROWS-1:0] cur_vec = '0;
  int cur_settle = 0, cur_lat = 0, exp_grp = 0;
  bit collide = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // column model: weighted sum of selected rows
  function automatic logic [AW-1:0] col_model(logic [ROWS-1:0] v, int c);
    int s = 100 + c;
    for (int r = 0; r < ROWS; r++) if (v[r]) s += ((r * 5 + c * 3) % 7) * 13;
    return AW'(s);
  endfunction

  function automatic logic [2*ROWS-1:0] code_of(logic [ROWS-1:0] v, logic [1:0] c);
    logic [2*ROWS-1:0] e = '0;
    for (int r = 0; r < ROWS; r++) if (v[r]) e[2*r +: 2] = c;
    return e;
  endfunction

  // ADC responder
  task automatic serve();
    int g = int'(col_grp_o);
    check(g == exp_grp, "R5 group order", 64'(g), 64'(exp_grp));
    exp_grp++;
    repeat (cur_lat) @(negedge clk);
    check(int'(col_grp_o) == g, "R4 group steady", 64'(col_grp_o), 64'(g));
    for (int k = 0; k < CH; k++) begin
      int c = g * CH + k;
      adc_data_i[k*AW +: AW] = (c < COLS) ? col_model(cur_vec, c) : 12'hFFF;
    end
    adc_done_i = 1'b1;
    if (collide && g == NGRP - 1) begin
      start_i = 1'b1;
      vec_i   = ~cur_vec;
    end
    @(negedge clk);
    adc_done_i = 1'b0;
    adc_data_i = '0;
    check(!adc_start_o, "R4 single pulse", 64'(adc_start_o), 64'd0);
    if (g != NGRP - 1) begin
      int w = 1;
      while (!adc_start_o) begin @(negedge clk); w++; end
      check(w == cur_settle + 2, "R6 inter-group settle", 64'(w), 64'(cur_settle + 2));
    end else if (collide) begin
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin
    @(negedge clk);
    forever begin
      if (adc_start_o) serve();
      else @(negedge clk);
    end
  end

  task automatic run_mvm(input logic [ROWS-1:0] v, input int n, input int lat,
                         input bit mid, input bit coll);
    int c;
    logic [2*ROWS-1:0] lp, ln;
    logic ld;
    cur_vec = v; cur_settle = n; cur_lat = lat; collide = coll; exp_grp = 0;
    @(negedge clk);
    vec_i = v; settle_cycles_i = 16'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !done_o, "R9 busy after start", {62'd0, busy_o, done_o}, 64'd2);
    check(pos_row_code_o == code_of(v, 2'b01), "R2 positive codes", 64'(pos_row_code_o), 64'(code_of(v, 2'b01)));
    check(neg_row_code_o == code_of(v, 2'b10), "R2 negative codes", 64'(neg_row_code_o), 64'(code_of(v, 2'b10)));
    if (mid) begin start_i = 1'b1; vec_i = ~v; settle_cycles_i = 16'(n + 5); end
    c = 0;
    while (!adc_start_o) begin
      @(negedge clk); c++;
      if (mid) start_i = 1'b0;
    end
    start_i = 1'b0;
    check(c == n + 1, "R3 first settle", 64'(c), 64'(n + 1));
    lp = pos_row_code_o; ln = neg_row_code_o; ld = done_o;
    while (busy_o) begin
      lp = pos_row_code_o; ln = neg_row_code_o; ld = done_o;
      @(negedge clk);
    end
    check(lp == '0 && ln == '0 && !ld, "R8 release before done", 64'(lp | ln), 64'd0);
    check(done_o, "R9 done after release", 64'(done_o), 64'd1);
    check(pos_row_code_o == '0 && neg_row_code_o == '0, "R8 idle codes", 64'(pos_row_code_o), 64'd0);
    check(exp_grp == NGRP, "R5 group count", 64'(exp_grp), 64'(NGRP));
    for (int k = 0; k < COLS; k++)
      check(result_o[k*AW +: AW] == col_model(v, k), "R7 column word",
            64'(result_o[k*AW +: AW]), 64'(col_model(v, k)));
  endtask

  localparam int NV = 6;
  localparam logic [36:0] TBL [NV] = '{
    {25'h1FFFFFF, 8'd3,  4'd1},
    {25'h0000001, 8'd0,  4'd0},
    {25'h1000000, 8'd1,  4'd2},
    {25'h0AAAAAA, 8'd7,  4'd3},
    {25'h0000000, 8'd2,  4'd0},
    {25'h1555555, 8'd12, 4'd5}
  };

  initial begin
    logic [COLS*AW-1:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !adc_start_o, "R1 flags", {61'd0, busy_o, done_o, adc_start_o}, 64'd0);
    check(pos_row_code_o == '0 && neg_row_code_o == '0, "R1 codes", 64'(pos_row_code_o), 64'd0);
    check(result_o == '0 && col_grp_o == '0, "R1 results", 64'(result_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_mvm(TBL[i][36:12], int'(TBL[i][11:4]), int'(TBL[i][3:0]), 1'b0, 1'b0);

    // R9 / R3: start while busy, with changed vector and settle, is ignored
    run_mvm(25'h0F0F0F3, 4, 1, 1'b1, 1'b0);

    // R9: start colliding with the final conversion and the release cycle
    run_mvm(25'h13579BD, 2, 0, 1'b0, 1'b1);
    repeat (3) begin
      @(negedge clk);
      check(!busy_o && done_o, "R9 collision ignored", {62'd0, busy_o, done_o}, 64'd1);
    end

    // R10: stray completion while idle
    snap = result_o;
    adc_data_i = {CH{12'h5A5}};
    adc_done_i = 1'b1;
    @(negedge clk);
    adc_done_i = 1'b0;
    adc_data_i = '0;
    @(negedge clk);
    check(result_o == snap, "R10 stray done", 64'(result_o), 64'(snap));
    check(!busy_o && !adc_start_o && done_o, "R10 no start", {61'd0, busy_o, adc_start_o, done_o}, 64'd1);

    // R7: results hold across idle time
    repeat (5) @(negedge clk);
    check(result_o == snap, "R7 hold", 64'(result_o), 64'(snap));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule